// File: doc/BRIEF.md
# Message Descriptor Stack Writer

This block keeps a running log of the messages a remote terminal handles on a dual-channel serial command/response bus. For every message it places a four-word record in a circular region of shared RAM: a status word, the time stamp taken when the message began, either a data block address or a mode-code data word, and the command word as received. The status word is first written with an "active" mark as soon as the message starts. When the message ends, the status word is written again with the final outcome. Software can therefore tell a message that is still running from one that has finished.

The block owns the record pointer, which is an offset from a programmable base address. The pointer steps by one record per finished message and wraps inside a region whose size is selectable. The block raises a one-cycle pulse when the pointer reaches the middle of the region and another when it wraps back to the start. Its only memory-side interface is a single 16-bit write port that writes one word per clock. Decoding of the serial bus and arbitration of host access to the RAM belong to other blocks.

Top module: `descStackWriter`

## Requirements
- R1: After reset, ramWe, irqHalf and irqFull are low and the record offset is zero, so the first record is written starting at baseAddr.
- R2: A msgStart seen while the block is idle leads to four writes on the four following cycles, one word per cycle, at baseAddr plus offset+0, +1, +2 and +3. The words are the status word, timeTag, the third word and cmdWord, in that order.
- R3: The status word written at start has bit 15 (active) = 1, bit 14 (finished) = 0, bit 13 = chanB, and every other bit 0.
- R4: The third word is modeData when both isModeCode and modeDataOpt are high at start. Otherwise it is dataPtr.
- R5: After a message has started, msgEnd causes one more write of the status word at offset+0, with bit 15 = 0, bit 14 = 1, bit 13 = chanB from start, bit 12 = illegalCmd and bits 3:0 = errFlags, the last two taken when msgEnd is seen. If msgEnd comes before or with the fourth word, this write follows that word at once. Otherwise it comes in the cycle after msgEnd. No write happens while the block waits for msgEnd.
- R6: After the completion write the offset advances by 4, so the next record starts 4 words further on.
- R7: The offset wraps modulo the region size of 256 << sizeSel words (sizeSel 0..3 gives 256, 512, 1024, 2048). When an advance wraps to zero, irqFull is high for exactly the one cycle after the completion write.
- R8: When an advance moves the offset from below half the region size to half or above, irqHalf is high for exactly the one cycle after the completion write.
- R9: msgStart is ignored while a record is being written or a message is open. No extra writes follow.
- R10: cmdWord, timeTag, dataPtr, modeData, chanB, isModeCode and modeDataOpt are captured at the accepted start. Later changes to these inputs do not alter the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 16 | RAM address of the region start |
| sizeSel | input | 2 | Region size select, 256 << sizeSel words |
| msgStart | input | 1 | Message start strobe |
| msgEnd | input | 1 | Message end strobe |
| cmdWord | input | 16 | Received command word |
| chanB | input | 1 | Message arrived on channel B (0 = channel A) |
| illegalCmd | input | 1 | Command was illegal |
| errFlags | input | 4 | Message error flags |
| timeTag | input | 16 | Current time stamp |
| dataPtr | input | 16 | Data block address |
| modeData | input | 16 | Mode-code data word |
| isModeCode | input | 1 | Command is a mode code |
| modeDataOpt | input | 1 | Store mode-code data in place of the address |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 16 | RAM write address |
| ramData | output | 16 | RAM write data |
| irqHalf | output | 1 | Midpoint crossing pulse |
| irqFull | output | 1 | Wrap pulse |

## Verification
A message can end while its opening record is still being written, so msgEnd may fall in any of the four start-write cycles, or even in the same cycle as msgStart. The stimulus table sweeps msgEnd across these positions and into the idle wait. For each case the bench checks that the completion write arrives immediately after the fourth word, or one cycle after a late msgEnd, and that it carries the flags present when msgEnd was asserted. The table also places a second msgStart inside a record, and the bench then checks that the port stays quiet.

// File: rtl/descStackPkg.sv
package descStackPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W0, ST_W1, ST_W2, ST_W3, ST_HOLD, ST_DONE
  } dsState_e;

  typedef enum logic [1:0] {
    SLOT_STAT, SLOT_TAG, SLOT_THIRD, SLOT_CMD
  } dsSlot_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capStart;
    logic    capEnd;
    logic    wrEn;
    dsSlot_e slot;
    logic    doneWord;
    logic    advance;
  } dsStrobe_t;

  localparam int STAT_ACTIVE = 15;
  localparam int STAT_DONE   = 14;
  localparam int STAT_CHAN   = 13;
  localparam int STAT_ILL    = 12;

endpackage

// File: rtl/dsCtrl.sv
module dsCtrl
  import descStackPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      msgStart,
  input  logic      msgEnd,
  output dsStrobe_t stb
);

  dsState_e state;
  logic     endPend;

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        stb.capStart = msgStart;
        stb.capEnd   = msgStart && msgEnd;
      end
      ST_W0: begin stb.wrEn = 1'b1; stb.slot = SLOT_STAT;  stb.capEnd = msgEnd; end
      ST_W1: begin stb.wrEn = 1'b1; stb.slot = SLOT_TAG;   stb.capEnd = msgEnd; end
      ST_W2: begin stb.wrEn = 1'b1; stb.slot = SLOT_THIRD; stb.capEnd = msgEnd; end
      ST_W3: begin stb.wrEn = 1'b1; stb.slot = SLOT_CMD;   stb.capEnd = msgEnd; end
      ST_HOLD: stb.capEnd = msgEnd;
      ST_DONE: begin
        stb.wrEn     = 1'b1;
        stb.slot     = SLOT_STAT;
        stb.doneWord = 1'b1;
        stb.advance  = 1'b1;
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      endPend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (msgStart) begin
          state   <= ST_W0;
          endPend <= msgEnd;
        end
        ST_W0: begin state <= ST_W1; endPend <= endPend | msgEnd; end
        ST_W1: begin state <= ST_W2; endPend <= endPend | msgEnd; end
        ST_W2: begin state <= ST_W3; endPend <= endPend | msgEnd; end
        ST_W3: begin
          state   <= (endPend || msgEnd) ? ST_DONE : ST_HOLD;
          endPend <= 1'b0;
        end
        ST_HOLD: if (msgEnd) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // an accepted start opens the record with the status word next cycle (R2)
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && msgStart) |=> (stb.wrEn && stb.slot == SLOT_STAT && !stb.doneWord));

  // completion write is a single cycle (R5)
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.doneWord |=> !stb.doneWord);

  // a record in progress never drops back to idle early (R9)
  p_busy_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_W0, ST_W1, ST_W2, ST_W3, ST_HOLD}) |=> (state != ST_IDLE));

endmodule

// File: rtl/dsPath.sv
module dsPath
  import descStackPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int ERR_W    = 4,
  parameter int MIN_LOG2 = 8,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dsStrobe_t         stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              chanB,
  input  logic              illegalCmd,
  input  logic [ERR_W-1:0]  errFlags,
  input  logic [DATA_W-1:0] timeTag,
  input  logic [DATA_W-1:0] dataPtr,
  input  logic [DATA_W-1:0] modeData,
  input  logic              isModeCode,
  input  logic              modeDataOpt,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              irqHalf,
  output logic              irqFull
);

  localparam int PTR_W = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam int STEP  = 4;

  logic [DATA_W-1:0] capCmd, capTag, capThird;
  logic              capChan, capIll;
  logic [ERR_W-1:0]  capErr;
  logic [PTR_W-1:0]  ptrOff;

  logic [PTR_W:0]    sizeWords, halfWords;
  logic [PTR_W-1:0]  sizeMask, curOff, nxtOff;
  logic              crossHalf, wrapped;
  logic [DATA_W-1:0] startStat, doneStat;

  assign sizeWords = (PTR_W+1)'(1) << (MIN_LOG2 + int'(sizeSel));
  assign halfWords = sizeWords >> 1;
  assign sizeMask  = PTR_W'(sizeWords - 1'b1);
  assign curOff    = ptrOff & sizeMask;
  assign nxtOff    = (curOff + PTR_W'(STEP)) & sizeMask;
  assign crossHalf = ({1'b0, curOff} < halfWords) && ({1'b0, nxtOff} >= halfWords);
  assign wrapped   = nxtOff < curOff;

  // capture of start-time and end-time fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capCmd   <= '0;
      capTag   <= '0;
      capThird <= '0;
      capChan  <= 1'b0;
      capIll   <= 1'b0;
      capErr   <= '0;
    end else begin
      if (stb.capStart) begin
        capCmd   <= cmdWord;
        capTag   <= timeTag;
        capThird <= (isModeCode && modeDataOpt) ? modeData : dataPtr;
        capChan  <= chanB;
      end
      if (stb.capEnd) begin
        capIll <= illegalCmd;
        capErr <= errFlags;
      end
    end
  end

  // record pointer and rollover pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrOff  <= '0;
      irqHalf <= 1'b0;
      irqFull <= 1'b0;
    end else begin
      irqHalf <= stb.advance && crossHalf;
      irqFull <= stb.advance && wrapped;
      if (stb.advance) ptrOff <= nxtOff;
    end
  end

  always_comb begin
    startStat = '0;
    startStat[STAT_ACTIVE] = 1'b1;
    startStat[STAT_CHAN]   = capChan;
    doneStat = '0;
    doneStat[ERR_W-1:0]    = capErr;
    doneStat[STAT_DONE]    = 1'b1;
    doneStat[STAT_CHAN]    = capChan;
    doneStat[STAT_ILL]     = capIll;
  end

  assign ramWe   = stb.wrEn;
  assign ramAddr = baseAddr + ADDR_W'(curOff) + ADDR_W'(stb.slot);

  always_comb begin
    unique case (stb.slot)
      SLOT_STAT:  ramData = stb.doneWord ? doneStat : startStat;
      SLOT_TAG:   ramData = capTag;
      SLOT_THIRD: ramData = capThird;
      SLOT_CMD:   ramData = capCmd;
      default:    ramData = '0;
    endcase
  end

  // wrap pulse is one cycle and leaves the offset at zero (R7)
  p_full_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqFull |=> !irqFull);
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqFull |-> (ptrOff == '0));

  // midpoint pulse leaves the offset in the upper half (R8)
  p_half_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqHalf |-> ({1'b0, ptrOff} >= halfWords));
  p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(irqHalf && irqFull));

  // captured command holds between starts (R10)
  p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capStart |=> $stable(capCmd));

endmodule

// File: rtl/descStackWriter.sv
module descStackWriter
  import descStackPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int ERR_W    = 4,
  parameter int MIN_LOG2 = 8,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic              msgStart,
  input  logic              msgEnd,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              chanB,
  input  logic              illegalCmd,
  input  logic [ERR_W-1:0]  errFlags,
  input  logic [DATA_W-1:0] timeTag,
  input  logic [DATA_W-1:0] dataPtr,
  input  logic [DATA_W-1:0] modeData,
  input  logic              isModeCode,
  input  logic              modeDataOpt,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              irqHalf,
  output logic              irqFull
);

  dsStrobe_t stb;

  dsCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .msgStart (msgStart),
    .msgEnd   (msgEnd),
    .stb      (stb)
  );

  dsPath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ERR_W    (ERR_W),
    .MIN_LOG2 (MIN_LOG2),
    .SEL_W    (SEL_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .baseAddr    (baseAddr),
    .sizeSel     (sizeSel),
    .cmdWord     (cmdWord),
    .chanB       (chanB),
    .illegalCmd  (illegalCmd),
    .errFlags    (errFlags),
    .timeTag     (timeTag),
    .dataPtr     (dataPtr),
    .modeData    (modeData),
    .isModeCode  (isModeCode),
    .modeDataOpt (modeDataOpt),
    .ramWe       (ramWe),
    .ramAddr     (ramAddr),
    .ramData     (ramData),
    .irqHalf     (irqHalf),
    .irqFull     (irqFull)
  );

endmodule

// File: tb/sim_descStackWriter.sv
`timescale 1ns/1ps
module sim_descStackWriter;

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] tag;
    logic [15:0] ptr;
    logic [15:0] mdat;
    logic        chanB;
    logic        isMode;
    logic        opt;
    logic        ill;
    logic [3:0]  err;
    logic [7:0]  endAt;
    logic        busy;
  } msgVec_t;

  localparam int NVEC = 6;
  localparam msgVec_t VECS [NVEC] = '{
    '{16'h0C21, 16'h1111, 16'h0400, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd7, 1'b0},
    '{16'h0FE1, 16'h2222, 16'h0480, 16'hA5A5, 1'b1, 1'b1, 1'b1, 1'b0, 4'h5, 8'd2, 1'b0},
    '{16'h07F2, 16'h3333, 16'h0500, 16'h5A5A, 1'b0, 1'b1, 1'b0, 1'b1, 4'h3, 8'd0, 1'b0},
    '{16'h1843, 16'h4444, 16'h0580, 16'h1357, 1'b1, 1'b0, 1'b0, 1'b0, 4'hA, 8'd9, 1'b1},
    '{16'h2864, 16'h5555, 16'h0600, 16'h2468, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 8'd4, 1'b0},
    '{16'h3085, 16'h6666, 16'h0680, 16'h9999, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 8'd5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baseAddr = 16'h1230;
  logic [1:0]  sizeSel = 2'd0;
  logic        msgStart = 1'b0, msgEnd = 1'b0;
  logic [15:0] cmdWord = '0, timeTag = '0, dataPtr = '0, modeData = '0;
  logic        chanB = 1'b0, illegalCmd = 1'b0, isModeCode = 1'b0, modeDataOpt = 1'b0;
  logic [3:0]  errFlags = '0;
  logic        ramWe, irqHalf, irqFull;
  logic [15:0] ramAddr, ramData;

  int total = 0;
  int bad = 0;
  int expOff = 0;

  always #2 clk = ~clk;

  descStackWriter u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .sizeSel(sizeSel),
    .msgStart(msgStart), .msgEnd(msgEnd), .cmdWord(cmdWord), .chanB(chanB),
    .illegalCmd(illegalCmd), .errFlags(errFlags), .timeTag(timeTag),
    .dataPtr(dataPtr), .modeData(modeData), .isModeCode(isModeCode),
    .modeDataOpt(modeDataOpt), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .irqHalf(irqHalf), .irqFull(irqFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic [1:0] sel);
    @(negedge clk);
    rstN = 1'b0; msgStart = 1'b0; msgEnd = 1'b0; sizeSel = sel;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expOff = 0;
    // R1: quiet port and idle pulses right after reset
    chk("R1 ramWe", 32'(ramWe), 32'd0);
    chk("R1 irqHalf", 32'(irqHalf), 32'd0);
    chk("R1 irqFull", 32'(irqFull), 32'd0);
  endtask

  task automatic runMsg(input msgVec_t v);
    int size = 256 << sizeSel;
    int doneC = (v.endAt <= 4) ? 5 : int'(v.endAt) + 1;
    int nxt = (expOff + 4) & (size - 1);
    logic [15:0] third = (v.isMode && v.opt) ? v.mdat : v.ptr;
    logic [15:0] sStat = 16'h8000 | (16'(v.chanB) << 13);
    logic [15:0] dStat = 16'h4000 | (16'(v.chanB) << 13) | (16'(v.ill) << 12) | 16'(v.err);
    logic [15:0] words [4];
    words[0] = sStat; words[1] = v.tag; words[2] = third; words[3] = v.cmd;
    for (int c = 0; c <= doneC + 1; c++) begin
      @(negedge clk);
      if (c >= 1 && c <= 4) begin
        chk("R2 we", 32'(ramWe), 32'd1);
        chk("R6 addr", 32'(ramAddr), 32'(16'(baseAddr + 16'(expOff) + 16'(c - 1))));
        case (c)
          1: chk("R3 start status", 32'(ramData), 32'(words[0]));
          2: chk("R2/R10 time tag", 32'(ramData), 32'(words[1]));
          3: chk("R4 third word", 32'(ramData), 32'(words[2]));
          default: chk("R2/R10 command", 32'(ramData), 32'(words[3]));
        endcase
      end else if (c > 4 && c < doneC) begin
        chk("R5 no write while open", 32'(ramWe), 32'd0);
      end else if (c == doneC) begin
        chk("R5 done we", 32'(ramWe), 32'd1);
        chk("R5 done addr", 32'(ramAddr), 32'(16'(baseAddr + 16'(expOff))));
        chk("R5 done status", 32'(ramData), 32'(dStat));
      end else if (c == doneC + 1) begin
        chk("R8 irqHalf", 32'(irqHalf), 32'(nxt == size / 2));
        chk("R7 irqFull", 32'(irqFull), 32'(nxt == 0));
        chk("R9 quiet after record", 32'(ramWe), 32'd0);
      end
      msgStart = (c == 0) || (v.busy && c == 2);
      msgEnd   = (c == int'(v.endAt));
      if (c == 0) begin
        cmdWord = v.cmd; timeTag = v.tag; dataPtr = v.ptr; modeData = v.mdat;
        chanB = v.chanB; isModeCode = v.isMode; modeDataOpt = v.opt;
      end else begin
        // R10: scramble start-time inputs after the accepted start
        cmdWord = ~v.cmd; timeTag = ~v.tag; dataPtr = ~v.ptr; modeData = ~v.mdat;
        chanB = ~v.chanB; isModeCode = ~v.isMode; modeDataOpt = ~v.opt;
      end
      illegalCmd = (c == int'(v.endAt)) ? v.ill : ~v.ill;
      errFlags   = (c == int'(v.endAt)) ? v.err : ~v.err;
    end
    expOff = nxt;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    msgVec_t g;
    doReset(2'd0);
    // table walk: end strobe placement, mode-code word, busy restarts
    for (int i = 0; i < NVEC; i++) runMsg(VECS[i]);
    // R7/R8: fill the 256-word region past both crossing points and wrap
    for (int i = 0; i < 66; i++) begin
      g = '{16'(i), 16'(i * 3), 16'(i + 16'h100), 16'hC0DE, i[0], 1'b0, 1'b0, 1'b0, 4'(i), 8'(3 + i % 4), 1'b0};
      runMsg(g);
    end
    // R1, R7: reset clears the offset, then the largest region wraps
    doReset(2'd3);
    for (int i = 0; i < 514; i++) begin
      g = '{16'(i), 16'(i + 7), 16'(i), 16'(i ^ 16'hFFFF), i[1], i[0], 1'b1, i[2], 4'(i >> 1), 8'd4, 1'b0};
      runMsg(g);
    end
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule